// File: doc/BRIEF.md
# Sleep and Wake Sequencing Controller

This block sequences the power states of a small microcontroller. Software requests sleep by setting a stop bit. The controller then halts the CPU. In the deep sleep variant it also withdraws the enable for every fast clock, so that only the 32 kHz low-speed clock keeps running. Any pending interrupt wakes the part. So does the controller's own periodic tick. On wake, the fast-clock enable returns at once. The CPU stays stalled for a hold-off window measured in low-speed clock phases: two phases when the PLL is enabled, so that it can settle, and one phase otherwise.

The controller runs on a free-running fast clock, `clk_i`. Downstream clock gates use `fclk_en_o`. The low-speed clock is treated as asynchronous. It passes through a two-flop synchronizer, and each of its edges counts as one phase. A sleep timer counts rising edges of the low-speed clock. It raises a sticky tick interrupt in every state, so it serves both for wake-and-poll in sleep and as a periodic interrupt in normal operation. The analog enable is owned by software. Entering sleep clears it, and waking does not restore it.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `cpu_run_o` and `fclk_en_o` are 1, and `analog_en_o` and `tick_irq_o` are 0.
- R2: In run, `stop_i`=1 with no wake source pending drops `cpu_run_o` on the next cycle. With a wake source pending (any `irq_i` bit or `tick_irq_o`), the CPU keeps running.
- R3: While sleeping with `deep_i`=1 (full sleep, captured when sleep is requested), `fclk_en_o` is 0. With `deep_i`=0 (CPU-only sleep), `fclk_en_o` stays 1. `cpu_run_o` is 0 in every sleep state.
- R4: A wake source seen while `fclk_en_o` is 0 makes `fclk_en_o` 1 on the next cycle.
- R5: After wake, the CPU stays stalled for 2 low-speed clock phases (edges) if `pll_en_i` was 1 at the wake, and for 1 phase if it was 0.
- R6: The CPU is not released while `stop_i` is 1. Once the hold-off has elapsed, clearing `stop_i` releases the CPU on the next cycle.
- R7: The tick flag sets once every 8^`tick_sel_i` rising edges of `lsclk_i`: code 0 gives 1, code 1 gives 8, code 2 gives 64 and code 3 gives 512.
- R8: `tick_irq_o` stays 1 until `tick_ack_i` is 1, and clears on the cycle after the acknowledge.
- R9: `analog_set_i` in run sets `analog_en_o`. Entering sleep clears it. Wake does not set it again, and `analog_set_i` has no effect outside run.
- R10: A wake source during the cycle of sleep entry aborts the entry. `fclk_en_o` never drops, and the controller goes straight to the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running fast clock of the controller |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lsclk_i | input | 1 | 32 kHz low-speed clock, asynchronous |
| stop_i | input | 1 | Stop bit from the status/control register; 1 requests sleep |
| pll_en_i | input | 1 | PLL enabled; selects the long hold-off |
| deep_i | input | 1 | 1 = full sleep, 0 = CPU-only sleep |
| irq_i | input | N_IRQ | Pending enabled interrupt requests |
| tick_sel_i | input | SEL_W | Sleep-timer period select |
| tick_ack_i | input | 1 | Acknowledge for the tick interrupt |
| analog_set_i | input | 1 | Software set of the analog enable |
| fclk_en_o | output | 1 | Enable for the fast clock gates |
| cpu_run_o | output | 1 | CPU run enable |
| analog_en_o | output | 1 | Analog block enable |
| tick_irq_o | output | 1 | Sticky periodic sleep-timer interrupt |

## Verification
The assertions check several rules on every cycle. The CPU never runs while the fast clock is gated. A gated clock reopens one cycle after any wake source. The CPU is released only after the hold-off counter reports done, and only with the stop bit clear. The tick flag rises only on a synchronized low-speed rising edge and holds until acknowledged. The analog enable rises only from a set issued in run. Other behaviour needs the bench's scenarios to show it: the exact number of low-speed phases spent in hold-off for each PLL setting, the tick period for each select code, abort of a sleep entry, and the analog enable staying low across a wake.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_HOLD  = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_lsync.sv
module swc_lsync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ls_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  // stages [0..SYNC_STAGES-1] synchronize, [LAST] holds previous value
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], ls_i};
  end

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall_o = ~sh_q[LAST-1] & sh_q[LAST];
endmodule

// File: rtl/swc_tick_timer.sv
module swc_tick_timer #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ack_i,
  output logic             flag_o
);
  localparam int unsigned CNT_W = STEP_LOG2 * ((1 << SEL_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] limit;
  logic             wrap;
  logic             flag_q;

  assign period = (CNT_W+1)'(1) << (STEP_LOG2 * 32'(sel_i));
  assign limit  = CNT_W'(period - (CNT_W+1)'(1));
  // >= so a smaller select after a change wraps immediately
  assign wrap   = rise_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (rise_i) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      // a new tick wins over an acknowledge in the same cycle
      flag_q <= wrap | (flag_q & ~ack_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/swc_holdoff.sv
module swc_holdoff #(
  parameter int unsigned PLL_PHASES  = 2,
  parameter int unsigned BASE_PHASES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic pll_i,
  input  logic phase_i,
  output logic done_o
);
  localparam int unsigned MAXP = (PLL_PHASES > BASE_PHASES) ? PLL_PHASES : BASE_PHASES;
  localparam int unsigned PH_W = $clog2(MAXP + 1);

  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      need_q <= PH_W'(PLL_PHASES);
    end else if (clr_i) begin
      cnt_q  <= '0;
      // tracks the PLL setting until the hold-off starts, then frozen
      need_q <= pll_i ? PH_W'(PLL_PHASES) : PH_W'(BASE_PHASES);
    end else if (phase_i && (cnt_q < need_q)) begin
      cnt_q <= cnt_q + PH_W'(1);
    end
  end

  assign done_o = !clr_i && (cnt_q >= need_q);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned N_IRQ       = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned STEP_LOG2   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PLL_PHASES  = 2,
  parameter int unsigned BASE_PHASES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lsclk_i,
  input  logic             stop_i,
  input  logic             pll_en_i,
  input  logic             deep_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [SEL_W-1:0] tick_sel_i,
  input  logic             tick_ack_i,
  input  logic             analog_set_i,
  output logic             fclk_en_o,
  output logic             cpu_run_o,
  output logic             analog_en_o,
  output logic             tick_irq_o
);
  swc_state_e state_q, state_d;
  logic deep_q, analog_q;
  logic ls_rise, ls_fall, hold_done, tick_flag, wake;

  swc_lsync #(.SYNC_STAGES(SYNC_STAGES)) u_lsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ls_i   (lsclk_i),
    .rise_o (ls_rise),
    .fall_o (ls_fall)
  );

  swc_tick_timer #(.SEL_W(SEL_W), .STEP_LOG2(STEP_LOG2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (ls_rise),
    .sel_i  (tick_sel_i),
    .ack_i  (tick_ack_i),
    .flag_o (tick_flag)
  );

  swc_holdoff #(.PLL_PHASES(PLL_PHASES), .BASE_PHASES(BASE_PHASES)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != ST_HOLD),
    .pll_i   (pll_en_i),
    .phase_i (ls_rise | ls_fall),
    .done_o  (hold_done)
  );

  assign wake = (|irq_i) | tick_flag;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (stop_i && !wake) state_d = ST_ENTER;
      ST_ENTER: state_d = wake ? ST_HOLD : ST_SLEEP;
      ST_SLEEP: if (wake) state_d = ST_HOLD;
      ST_HOLD:  if (hold_done && !stop_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      deep_q   <= 1'b0;
      analog_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && state_d == ST_ENTER) deep_q <= deep_i;
      if (state_q == ST_ENTER && state_d == ST_SLEEP) analog_q <= 1'b0;
      else if (state_q == ST_RUN && analog_set_i)     analog_q <= 1'b1;
    end
  end

  assign fclk_en_o   = !(state_q == ST_SLEEP && deep_q);
  assign cpu_run_o   = (state_q == ST_RUN);
  assign analog_en_o = analog_q;
  assign tick_irq_o  = tick_flag;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic [N_IRQ-1:0] irq_i,
  input logic             tick_ack_i,
  input logic             analog_set_i,
  input logic             fclk_en_o,
  input logic             cpu_run_o,
  input logic             analog_en_o,
  input logic             tick_irq_o,
  input logic             hold_done_i,
  input logic             ls_rise_i
);
  a_r2_halt_needs_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_run_o) |-> $past(stop_i));

  a_r3_gated_cpu_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fclk_en_o |-> !cpu_run_o);

  a_r4_wake_ungates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fclk_en_o && ((|irq_i) || tick_irq_o)) |=> fclk_en_o);

  a_r5_release_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_run_o) |-> $past(hold_done_i));

  a_r6_release_stop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_run_o) |-> !$past(stop_i));

  a_r7_tick_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick_irq_o) |-> $past(ls_rise_i));

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_irq_o && !tick_ack_i) |=> tick_irq_o);

  a_r9_analog_set_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(analog_en_o) |-> $past(analog_set_i && cpu_run_o));
endmodule

bind sleep_wake_ctrl swc_checker #(.N_IRQ(N_IRQ)) u_swc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .irq_i        (irq_i),
  .tick_ack_i   (tick_ack_i),
  .analog_set_i (analog_set_i),
  .fclk_en_o    (fclk_en_o),
  .cpu_run_o    (cpu_run_o),
  .analog_en_o  (analog_en_o),
  .tick_irq_o   (tick_irq_o),
  .hold_done_i  (hold_done),
  .ls_rise_i    (ls_rise)
);

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
  localparam int N_IRQ = 4;
  localparam int HALF  = 20;  // fast cycles per low-speed phase
  // {pll, deep, irq_idx[1:0], exp_fclk_sleep, exp_phases[1:0]}
  localparam int NV = 4;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'd0, 1'b0, 2'd2},
    {1'b0, 1'b1, 2'd1, 1'b0, 2'd1},
    {1'b1, 1'b0, 2'd2, 1'b1, 2'd2},
    {1'b0, 1'b0, 2'd3, 1'b1, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lsclk = 1'b0, stop = 1'b0, pll_en = 1'b0, deep = 1'b0;
  logic [N_IRQ-1:0] irq = '0;
  logic [1:0] tsel = 2'd0;
  logic tack = 1'b0, aset = 1'b0;
  logic fclk_en, cpu_run, analog_en, tick_irq;
  int checks = 0, errors = 0, cyc = 0, ls_div = 0, ls_toggles = 0, ls_rises = 0;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ)) u_sleep_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lsclk_i(lsclk), .stop_i(stop), .pll_en_i(pll_en),
    .deep_i(deep), .irq_i(irq), .tick_sel_i(tsel), .tick_ack_i(tack),
    .analog_set_i(aset), .fclk_en_o(fclk_en), .cpu_run_o(cpu_run),
    .analog_en_o(analog_en), .tick_irq_o(tick_irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (ls_div == HALF - 1) begin
      ls_div     <= 0;
      lsclk      <= ~lsclk;
      ls_toggles <= ls_toggles + 1;
      if (!lsclk) ls_rises <= ls_rises + 1;
    end else ls_div <= ls_div + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_toggle();
    int t = ls_toggles;
    while (ls_toggles == t) @(negedge clk);
  endtask

  task automatic wait_run();
    for (int i = 0; i < 400 && !cpu_run; i++) @(negedge clk);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 30000 && !tick_irq; i++) @(negedge clk);
  endtask

  task automatic ack();
    tack = 1'b1; step(1); tack = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 cpu_run", cpu_run, 1);
    chk("R1 fclk_en", fclk_en, 1);
    chk("R1 analog_en", analog_en, 0);
    chk("R1 tick_irq", tick_irq, 0);

    // R7 tick periods, R8 stickiness
    for (int s = 0; s < 4; s++) begin
      int r0;
      tsel = 2'(s);
      wait_tick();
      if (s == 0) begin
        step(5);
        chk("R8 flag held without ack", tick_irq, 1);
      end
      r0 = ls_rises;
      ack();
      chk("R8 flag cleared by ack", tick_irq, 0);
      wait_tick();
      chk("R7 tick period", ls_rises - r0, 8 ** s);
      ack();
    end

    // sleep scenario table: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int t0, ph;
      pll_en = VEC[v][6]; deep = VEC[v][5]; stop = 1'b1;
      step(1);
      chk("R2 cpu halted on stop", cpu_run, 0);
      step(3);
      chk("R3 fclk_en in sleep", fclk_en, int'(VEC[v][2]));
      chk("R3 cpu_run in sleep", cpu_run, 0);
      wait_toggle(); step(5);
      t0 = ls_toggles;
      irq[VEC[v][4:3]] = 1'b1; stop = 1'b0;
      step(1);
      chk("R4 fclk_en after wake", fclk_en, 1);
      irq = '0;
      wait_run();
      ph = ls_toggles - t0;
      chk("R5 hold-off phases", ph, int'(VEC[v][1:0]));
      step(2);
    end

    // R6 stop still set blocks release
    deep = 1'b1; pll_en = 1'b0; stop = 1'b1;
    step(4);
    wait_toggle(); step(5);
    irq[0] = 1'b1; step(1); irq = '0;
    for (int k = 0; k < 4; k++) wait_toggle();
    step(4);
    chk("R6 held while stop set", cpu_run, 0);
    stop = 1'b0; step(1);
    chk("R6 released after stop clear", cpu_run, 1);

    // R2 wake pending blocks entry
    irq[2] = 1'b1; stop = 1'b1;
    step(3);
    chk("R2 entry blocked by pending irq", cpu_run, 1);
    irq = '0; stop = 1'b0; step(2);

    // R10 abort during entry
    begin
      int drops = 0;
      deep = 1'b1; stop = 1'b1; step(1);
      irq[1] = 1'b1; step(1); irq = '0;
      for (int k = 0; k < 60; k++) begin
        if (!fclk_en) drops++;
        @(negedge clk);
      end
      chk("R10 fclk never dropped", drops, 0);
      chk("R10 cpu stalled in hold", cpu_run, 0);
      stop = 1'b0; wait_run();
      chk("R10 resumes after abort", cpu_run, 1);
    end

    // R9 analog enable ownership
    aset = 1'b1; step(1); aset = 1'b0; step(1);
    chk("R9 analog set in run", analog_en, 1);
    deep = 1'b0; stop = 1'b1; step(4);
    chk("R9 analog cleared on sleep", analog_en, 0);
    aset = 1'b1; step(1); aset = 1'b0; step(1);
    chk("R9 set ignored in sleep", analog_en, 0);
    wait_toggle(); step(5);
    irq[3] = 1'b1; stop = 1'b0; step(1); irq = '0;
    wait_run(); step(2);
    chk("R9 analog stays low after wake", analog_en, 0);
    aset = 1'b1; step(1); aset = 1'b0; step(1);
    chk("R9 analog set again in run", analog_en, 1);

    // R4 tick as wake source from full sleep
    tsel = 2'd0; wait_tick(); ack();
    deep = 1'b1; stop = 1'b1; step(4);
    chk("R3 full sleep gates fclk", fclk_en, 0);
    wait_tick(); step(1);
    chk("R4 tick wakes fclk", fclk_en, 1);
    stop = 1'b0; wait_run();
    chk("R5 run after tick wake", cpu_run, 1);
    ack();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule